// File: doc/BRIEF.md
# Link Event Counter Unit

This block watches the traffic events of one interconnect link and counts them on eight 64-bit counters. Each clock cycle it may receive pulses for five kinds of event: request received, data received, request sent, data sent, and cycle tick. A single set of tags (source ID, target ID, trace bit) comes with them. Software programs the block through a simple register port. A narrow access moves 32 bits. A wide access moves a whole 64-bit counter in one cycle.

Each counter holds an 8-bit event code that picks which pulse it follows. Counting can be narrowed by three request filters: an inclusive target-ID window, a source-ID compare under a don't-care mask, and a required trace bit. A small run-state machine derives its state from the control register. Its states are HALT, OPEN (counting, no filtering) and FILTERED (counting, filters applied). The START transition leaves HALT when the run bit is set. STOP returns to HALT when the run bit is cleared. FILTER_ON moves from OPEN to FILTERED and FILTER_OFF moves back. Because the state is registered, counting begins or ends on the second clock edge after the control write. When a counter wraps, it latches a status bit. A maskable interrupt line reports these status bits.

Top module: `lnk_evctr`

## Requirements
- R1: After reset, every register and counter reads zero, except the interrupt mask at byte offset 0x018, which reads all ones. The irq output is low, and the identity word at 0x024 returns the ID_VALUE parameter.
- R2: Counter n sits at byte offset 0x100 + 8n. A narrow access reads or writes its low half at that offset and its high half at offset +4. A wide access (bus_wide=1) at that offset reads or writes all 64 bits.
- R3: Counter n takes its 8-bit code from byte lane n mod 4 (bits 8*(n mod 4)+7 : 8*(n mod 4)) of the select word at 0x010 + 4*(n/4). The codes 0x30, 0x31, 0x34, 0x35 and 0x09 follow ev_pulse bits 0, 1, 2, 3 and 4 respectively. Any other code, including every code of 0x80 or above, counts nothing.
- R4: The control word is at 0x000, and the counter enable word at 0x00C has bit n for counter n. A counter advances only while control bit 0 (run) and its own enable bit are both set. The state machine moves HALT to OPEN or FILTERED (START), OPEN to FILTERED (FILTER_ON) and back (FILTER_OFF), and either running state to HALT (STOP).
- R5: Control bit 5 enables the target filter. The window word at 0x004 holds the minimum in bits 11:1 and the maximum in bits 22:12. An event passes if min <= ev_tgt <= max, bounds included. A window with max = 0 or max < min does not restrict anything.
- R6: Control bit 4 enables the source filter. The word at 0x008 holds the command in bits 11:1 and the mask in bits 22:12. An event passes if (ev_src & ~mask) == (cmd & ~mask). A command of zero disables the source filter.
- R7: Control bit 2 enables the trace filter. With it on, only events with ev_trace = 1 count.
- R8: Filters apply only while control bit 1 is set, and an event must then pass every enabled filter. The cycle code 0x09 is never filtered.
- R9: An increment from all ones wraps the counter to zero and sets status bit n (read-only word at 0x01C). Writing 1 to bit n at 0x020 clears that status bit. A wrap in the same cycle as a clear leaves the bit set.
- R10: irq is high exactly when some status bit is set whose mask bit (0x018, 1 = masked) is zero.
- R11: A software write to a counter wins over an increment in the same cycle. The counter then holds the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wide | input | 1 | 1 = 64-bit counter access, 0 = 32-bit register access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 64 | Write data (narrow writes use bits 31:0) |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| ev_pulse | input | 5 | Event pulses: rx request, rx data, tx request, tx data, cycle tick |
| ev_src | input | 11 | Source ID tag of this cycle's events |
| ev_tgt | input | 11 | Target ID tag of this cycle's events |
| ev_trace | input | 1 | Trace bit of this cycle's events |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest conditions to reach are a 64-bit wrap and its collision with a status clear in the same cycle. Counting up to the wrap is out of reach. The bench instead loads the counter with all ones through a wide write. It then asserts a single cycle-tick pulse in the same cycle as a write-1-to-clear to the status word. The software-write-versus-increment race is reached the same way. The tick input is held high while a wide write lands on the counter, and the bench then reads the counter on the next two falling edges.

// File: rtl/lnk_evctr_pkg.sv
package lnk_evctr_pkg;

    typedef enum logic [1:0] {
        ST_HALT     = 2'd0,
        ST_OPEN     = 2'd1,
        ST_FILTERED = 2'd2
    } run_state_e;

    // pulse lane of each event kind
    localparam int P_RX_REQ  = 0;
    localparam int P_RX_DATA = 1;
    localparam int P_TX_REQ  = 2;
    localparam int P_TX_DATA = 3;
    localparam int P_TICK    = 4;
    localparam int NPULSE    = 5;

    localparam logic [7:0] CODE_RX_REQ  = 8'h30;
    localparam logic [7:0] CODE_RX_DATA = 8'h31;
    localparam logic [7:0] CODE_TX_REQ  = 8'h34;
    localparam logic [7:0] CODE_TX_DATA = 8'h35;
    localparam logic [7:0] CODE_TICK    = 8'h09;

    // control word bit positions
    localparam int C_RUN   = 0;
    localparam int C_FILT  = 1;
    localparam int C_TRACE = 2;
    localparam int C_SRC   = 4;
    localparam int C_TGT   = 5;
    localparam logic [5:0] CTRL_WMASK = 6'b110111;

    // field shifts inside the window and source words
    localparam int SH_LO = 1;
    localparam int SH_HI = 12;

    // byte offsets
    localparam int A_CTRL  = 'h000;
    localparam int A_TGT   = 'h004;
    localparam int A_SRC   = 'h008;
    localparam int A_CEN   = 'h00C;
    localparam int A_SEL0  = 'h010;
    localparam int A_IMASK = 'h018;
    localparam int A_ISTAT = 'h01C;
    localparam int A_ICLR  = 'h020;
    localparam int A_IDENT = 'h024;
    localparam int A_CNT   = 'h100;

endpackage

// File: rtl/lnk_evctr_match.sv
module lnk_evctr_match
    import lnk_evctr_pkg::*;
(
    input  logic [7:0]        code,
    input  logic [NPULSE-1:0] pulse,
    output logic              hit,
    output logic              is_tick
);

    always_comb begin
        hit     = 1'b0;
        is_tick = 1'b0;
        case (code)
            CODE_RX_REQ:  hit = pulse[P_RX_REQ];
            CODE_RX_DATA: hit = pulse[P_RX_DATA];
            CODE_TX_REQ:  hit = pulse[P_TX_REQ];
            CODE_TX_DATA: hit = pulse[P_TX_DATA];
            CODE_TICK: begin
                hit     = pulse[P_TICK];
                is_tick = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/lnk_evctr_filter.sv
module lnk_evctr_filter #(
    parameter int IDW = 11
) (
    input  logic           apply,
    input  logic           tgt_on,
    input  logic           src_on,
    input  logic           trace_on,
    input  logic [IDW-1:0] win_lo,
    input  logic [IDW-1:0] win_hi,
    input  logic [IDW-1:0] src_cmd,
    input  logic [IDW-1:0] src_dc,
    input  logic [IDW-1:0] tag_tgt,
    input  logic [IDW-1:0] tag_src,
    input  logic           tag_trace,
    output logic           pass
);

    logic win_real, tgt_ok, src_ok, trace_ok;

    always_comb begin
        win_real = (win_hi != '0) && (win_hi >= win_lo);
        tgt_ok   = !tgt_on || !win_real ||
                   ((tag_tgt >= win_lo) && (tag_tgt <= win_hi));
        src_ok   = !src_on || (src_cmd == '0) ||
                   ((tag_src & ~src_dc) == (src_cmd & ~src_dc));
        trace_ok = !trace_on || tag_trace;
        pass     = !apply || (tgt_ok && src_ok && trace_ok);
    end

endmodule

// File: rtl/lnk_evctr_counter.sv
module lnk_evctr_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    assign wrap = inc && !ld && (cnt == {CW{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (inc) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/lnk_evctr.sv
module lnk_evctr
    import lnk_evctr_pkg::*;
#(
    parameter int          NCNT     = 8,
    parameter int          CW       = 64,
    parameter int          IDW      = 11,
    parameter int          AW       = 12,
    parameter logic [31:0] ID_VALUE = 32'h0A11_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [AW-1:0]     bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    input  logic [NPULSE-1:0] ev_pulse,
    input  logic [IDW-1:0]    ev_src,
    input  logic [IDW-1:0]    ev_tgt,
    input  logic              ev_trace,
    output logic              irq
);

    localparam int NSEL = (NCNT + 3) / 4;
    localparam int HIW  = CW - 32;

    logic [5:0]            ctrl_q;
    logic [IDW-1:0]        win_lo_q, win_hi_q, cmd_q, dc_q;
    logic [NCNT-1:0]       cen_q, imask_q, istat_q;
    logic [NCNT-1:0][7:0]  sel_q;
    logic [CW-1:0]         cnt_q [NCNT];
    logic [NCNT-1:0]       inc_v, wrap_v;
    logic                  nwr, run_gate, filt_gate, pass;
    run_state_e            state_q, state_d;

    assign nwr = bus_wr && !bus_wide;

    // ---------------- run-state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin                          // START
                if (ctrl_q[C_RUN]) state_d = ctrl_q[C_FILT] ? ST_FILTERED : ST_OPEN;
            end
            ST_OPEN: begin
                if (!ctrl_q[C_RUN])     state_d = ST_HALT;      // STOP
                else if (ctrl_q[C_FILT]) state_d = ST_FILTERED; // FILTER_ON
            end
            ST_FILTERED: begin
                if (!ctrl_q[C_RUN])      state_d = ST_HALT;     // STOP
                else if (!ctrl_q[C_FILT]) state_d = ST_OPEN;    // FILTER_OFF
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run_gate  = 1'b0;
        filt_gate = 1'b0;
        unique case (state_q)
            ST_HALT: ;
            ST_OPEN: run_gate = 1'b1;
            ST_FILTERED: begin
                run_gate  = 1'b1;
                filt_gate = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            win_lo_q <= '0;
            win_hi_q <= '0;
            cmd_q    <= '0;
            dc_q     <= '0;
            cen_q    <= '0;
            imask_q  <= '1;
            sel_q    <= '0;
        end else if (nwr) begin
            if (bus_addr == AW'(A_CTRL)) ctrl_q <= bus_wdata[5:0] & CTRL_WMASK;
            if (bus_addr == AW'(A_TGT)) begin
                win_lo_q <= bus_wdata[SH_LO +: IDW];
                win_hi_q <= bus_wdata[SH_HI +: IDW];
            end
            if (bus_addr == AW'(A_SRC)) begin
                cmd_q <= bus_wdata[SH_LO +: IDW];
                dc_q  <= bus_wdata[SH_HI +: IDW];
            end
            if (bus_addr == AW'(A_CEN))   cen_q   <= bus_wdata[NCNT-1:0];
            if (bus_addr == AW'(A_IMASK)) imask_q <= bus_wdata[NCNT-1:0];
            for (int s = 0; s < NSEL; s++) begin
                if (bus_addr == AW'(A_SEL0 + 4 * s)) begin
                    for (int b = 0; b < 4; b++) begin
                        if (4 * s + b < NCNT) sel_q[4 * s + b] <= bus_wdata[8 * b +: 8];
                    end
                end
            end
        end
    end

    // ---------------- overflow status ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            istat_q <= '0;
        end else begin
            for (int i = 0; i < NCNT; i++) begin
                if (wrap_v[i])
                    istat_q[i] <= 1'b1;
                else if (nwr && bus_addr == AW'(A_ICLR) && bus_wdata[i])
                    istat_q[i] <= 1'b0;
            end
        end
    end

    assign irq = |(istat_q & ~imask_q);

    // ---------------- shared filter ----------------
    lnk_evctr_filter #(.IDW(IDW)) u_filter (
        .apply    (filt_gate),
        .tgt_on   (ctrl_q[C_TGT]),
        .src_on   (ctrl_q[C_SRC]),
        .trace_on (ctrl_q[C_TRACE]),
        .win_lo   (win_lo_q),
        .win_hi   (win_hi_q),
        .src_cmd  (cmd_q),
        .src_dc   (dc_q),
        .tag_tgt  (ev_tgt),
        .tag_src  (ev_src),
        .tag_trace(ev_trace),
        .pass     (pass)
    );

    // ---------------- counter slices ----------------
    for (genvar g = 0; g < NCNT; g++) begin : g_ctr
        logic          hit, is_tick, ld_lo, ld_hi, ld_full;
        logic [CW-1:0] ld_val;

        lnk_evctr_match u_match (
            .code   (sel_q[g]),
            .pulse  (ev_pulse),
            .hit    (hit),
            .is_tick(is_tick)
        );

        assign ld_lo   = nwr && (bus_addr == AW'(A_CNT + 8 * g));
        assign ld_hi   = nwr && (bus_addr == AW'(A_CNT + 8 * g + 4));
        assign ld_full = bus_wr && bus_wide && (bus_addr == AW'(A_CNT + 8 * g));

        always_comb begin
            if (ld_full)    ld_val = bus_wdata[CW-1:0];
            else if (ld_lo) ld_val = {cnt_q[g][CW-1:32], bus_wdata[31:0]};
            else            ld_val = {bus_wdata[HIW-1:0], cnt_q[g][31:0]};
        end

        assign inc_v[g] = run_gate && cen_q[g] && hit && (is_tick || pass);

        lnk_evctr_counter #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_v[g]),
            .ld    (ld_lo || ld_hi || ld_full),
            .ld_val(ld_val),
            .cnt   (cnt_q[g]),
            .wrap  (wrap_v[g])
        );
    end

    // ---------------- read mux ----------------
    always_comb begin
        logic [31:0] word;
        word      = '0;
        bus_rdata = '0;
        if (bus_wide) begin
            for (int i = 0; i < NCNT; i++)
                if (bus_addr == AW'(A_CNT + 8 * i)) bus_rdata = 64'(cnt_q[i]);
        end else begin
            if (bus_addr == AW'(A_CTRL)) word = 32'(ctrl_q);
            if (bus_addr == AW'(A_TGT)) begin
                word[SH_LO +: IDW] = win_lo_q;
                word[SH_HI +: IDW] = win_hi_q;
            end
            if (bus_addr == AW'(A_SRC)) begin
                word[SH_LO +: IDW] = cmd_q;
                word[SH_HI +: IDW] = dc_q;
            end
            if (bus_addr == AW'(A_CEN))   word = 32'(cen_q);
            if (bus_addr == AW'(A_IMASK)) word = 32'(imask_q);
            if (bus_addr == AW'(A_ISTAT)) word = 32'(istat_q);
            if (bus_addr == AW'(A_IDENT)) word = ID_VALUE;
            for (int s = 0; s < NSEL; s++) begin
                if (bus_addr == AW'(A_SEL0 + 4 * s)) begin
                    for (int b = 0; b < 4; b++)
                        if (4 * s + b < NCNT) word[8 * b +: 8] = sel_q[4 * s + b];
                end
            end
            for (int i = 0; i < NCNT; i++) begin
                if (bus_addr == AW'(A_CNT + 8 * i))     word = cnt_q[i][31:0];
                if (bus_addr == AW'(A_CNT + 8 * i + 4)) word = 32'(cnt_q[i][CW-1:32]);
            end
            bus_rdata = {32'b0, word};
        end
    end

endmodule

// File: rtl/lnk_evctr_chk.sv
module lnk_evctr_chk
    import lnk_evctr_pkg::*;
#(
    parameter int NCNT = 8,
    parameter int CW   = 64,
    parameter int AW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_wide,
    input  logic [AW-1:0]   bus_addr,
    input  logic [63:0]     bus_wdata,
    input  logic [CW-1:0]   cnt0,
    input  logic            inc0,
    input  logic            en0,
    input  run_state_e      state,
    input  logic [NCNT-1:0] stat,
    input  logic [NCNT-1:0] mask,
    input  logic            irq
);

    // R11: a wide write to counter 0 lands exactly, whatever else happens
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wide && bus_addr == AW'(A_CNT)) |=> (cnt0 == $past(bus_wdata[CW-1:0])));

    // R4: a halted unit does not move counter 0
    a_r4_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !bus_wr) |=> $stable(cnt0));

    // R4: a disabled counter does not move
    a_r4_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en0 && !bus_wr) |=> $stable(cnt0));

    // R9: increment from all ones wraps to zero and flags status
    a_r9_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (inc0 && cnt0 == {CW{1'b1}} && !bus_wr) |=> (cnt0 == '0 && stat[0]));

    // R9: a status bit stays set until a matching clear write
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && !(bus_wr && !bus_wide && bus_addr == AW'(A_ICLR) && bus_wdata[0])) |=> stat[0]);

    // R10: the line needs a pending status, and all-masked keeps it quiet
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0));
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq);

endmodule

bind lnk_evctr lnk_evctr_chk #(.NCNT(NCNT), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_wide (bus_wide),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt0     (cnt_q[0]),
    .inc0     (inc_v[0]),
    .en0      (cen_q[0]),
    .state    (state_q),
    .stat     (istat_q),
    .mask     (imask_q),
    .irq      (irq)
);

// File: tb/lnk_evctr_bench.sv
`timescale 1ns/1ps
module lnk_evctr_bench;
    localparam int AW = 12;
    localparam logic [31:0] IDV = 32'h0A11_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_wide = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0, bus_rdata;
    logic [4:0]  ev_pulse = '0;
    logic [10:0] ev_src = '0, ev_tgt = '0;
    logic        ev_trace = 1'b0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lnk_evctr #(.ID_VALUE(IDV)) u_lnk_evctr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pulse(ev_pulse), .ev_src(ev_src), .ev_tgt(ev_tgt),
        .ev_trace(ev_trace), .irq(irq)
    );

    // {req4, code8, pulse5, ctrl8, tgt11, src11, trace1, expected1}
    localparam int VW = 49;
    localparam int NV = 17;
    localparam logic [VW-1:0] TBL [NV] = '{
        {4'd3, 8'h30, 5'b00001, 8'h01, 11'd5,  11'h000, 1'b0, 1'b1}, // R3 open count
        {4'd3, 8'h30, 5'b00010, 8'h01, 11'd5,  11'h000, 1'b0, 1'b0}, // R3 other lane
        {4'd3, 8'h31, 5'b00010, 8'h01, 11'd5,  11'h000, 1'b0, 1'b1}, // R3
        {4'd5, 8'h34, 5'b00100, 8'h23, 11'd10, 11'h000, 1'b0, 1'b1}, // R5 min edge
        {4'd5, 8'h34, 5'b00100, 8'h23, 11'd20, 11'h000, 1'b0, 1'b1}, // R5 max edge
        {4'd5, 8'h34, 5'b00100, 8'h23, 11'd21, 11'h000, 1'b0, 1'b0}, // R5 above
        {4'd5, 8'h34, 5'b00100, 8'h23, 11'd9,  11'h000, 1'b0, 1'b0}, // R5 below
        {4'd6, 8'h35, 5'b01000, 8'h13, 11'd0,  11'h0AB, 1'b0, 1'b1}, // R6 masked match
        {4'd6, 8'h35, 5'b01000, 8'h13, 11'd0,  11'h0B0, 1'b0, 1'b0}, // R6 mismatch
        {4'd7, 8'h30, 5'b00001, 8'h07, 11'd0,  11'h000, 1'b0, 1'b0}, // R7 no tag
        {4'd7, 8'h30, 5'b00001, 8'h07, 11'd0,  11'h000, 1'b1, 1'b1}, // R7 tagged
        {4'd8, 8'h09, 5'b10000, 8'h37, 11'd0,  11'h000, 1'b0, 1'b1}, // R8 tick bypass
        {4'd4, 8'h30, 5'b00001, 8'h02, 11'd0,  11'h000, 1'b0, 1'b0}, // R4 run off
        {4'd3, 8'h85, 5'b11111, 8'h01, 11'd0,  11'h000, 1'b0, 1'b0}, // R3 high code
        {4'd3, 8'h32, 5'b11111, 8'h01, 11'd0,  11'h000, 1'b0, 1'b0}, // R3 unassigned
        {4'd8, 8'h30, 5'b00001, 8'h03, 11'd99, 11'h000, 1'b0, 1'b1}, // R8 no sub-filter
        {4'd8, 8'h30, 5'b00001, 8'h31, 11'd99, 11'h7FF, 1'b0, 1'b1}  // R8 master off
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr32(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_wide = 1'b0; bus_addr = AW'(a); bus_wdata = {32'b0, d};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr64(input int a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_wide = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input int a, input logic wide, output logic [63:0] v);
        bus_addr = AW'(a); bus_wide = wide;
        #1;
        v = bus_rdata;
        bus_wide = 1'b0;
    endtask

    task automatic fire(input logic [4:0] p, input logic [10:0] s, input logic [10:0] t, input logic tr);
        @(negedge clk);
        ev_pulse = p; ev_src = s; ev_tgt = t; ev_trace = tr;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h000, 0, v); check("R1 ctrl", v, 0);
        rd('h018, 0, v); check("R1 mask", v, 64'hFF);
        rd('h01C, 0, v); check("R1 status", v, 0);
        rd('h024, 0, v); check("R1 ident", v, {32'b0, IDV});
        rd('h100, 1, v); check("R1 counter", v, 0);
        check("R1 irq", {63'b0, irq}, 0);

        // table walk on counter 0
        wr32('h004, (32'd20 << 12) | (32'd10 << 1));
        wr32('h008, (32'h00F << 12) | (32'h0A0 << 1));
        wr32('h00C, 32'h1);
        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] e;
            e = TBL[k];
            wr64('h100, 64'd0);
            wr32('h010, {24'b0, e[44:37]});
            wr32('h000, {24'b0, e[31:24]});
            settle();
            fire(e[36:32], e[12:2], e[23:13], e[1]);
            rd('h100, 0, v);
            check($sformatf("R%0d vector %0d", e[48:45], k), v, {63'b0, e[0]});
        end

        // R5 window with max = 0 and max < min restricts nothing
        wr64('h100, 64'd0);
        wr32('h010, 32'h30);
        wr32('h004, (32'd0 << 12) | (32'd5 << 1));
        wr32('h000, 32'h23);
        settle();
        fire(5'b00001, 11'd0, 11'd500, 1'b0);
        wr32('h004, (32'd3 << 12) | (32'd7 << 1));
        fire(5'b00001, 11'd0, 11'd500, 1'b0);
        rd('h100, 0, v); check("R5 void window", v, 2);

        // R6 zero command disables source compare
        wr32('h008, 32'h0);
        wr32('h000, 32'h13);
        settle();
        fire(5'b00001, 11'h7FF, 11'd0, 1'b0);
        rd('h100, 0, v); check("R6 zero cmd", v, 3);

        // R4 per-counter enable, R3 upper select word lanes
        wr32('h000, 32'h01);
        wr32('h00C, 32'h20);
        wr32('h010, 32'h30303030);
        wr32('h014, 32'h00003100);
        wr64('h100, 64'd0);
        settle();
        fire(5'b00011, 11'd0, 11'd0, 1'b0);
        rd('h100, 1, v); check("R4 disabled counter", v, 0);
        rd('h128, 1, v); check("R3 counter5 lane1", v, 1);

        // R2 wide and narrow access
        wr64('h118, 64'h1234_5678_9ABC_DEF0);
        rd('h118, 0, v); check("R2 low half", v, 64'h9ABC_DEF0);
        rd('h11C, 0, v); check("R2 high half", v, 64'h1234_5678);
        wr32('h11C, 32'hCAFE_F00D);
        rd('h118, 1, v); check("R2 wide read", v, 64'hCAFE_F00D_9ABC_DEF0);

        // R9 / R10 overflow
        wr32('h00C, 32'h04);
        wr32('h010, 32'h00090000);
        wr64('h110, 64'hFFFF_FFFF_FFFF_FFFF);
        settle();
        fire(5'b10000, 11'd0, 11'd0, 1'b0);
        rd('h110, 1, v); check("R9 wrap to zero", v, 0);
        rd('h01C, 0, v); check("R9 status set", v, 64'h04);
        check("R10 masked", {63'b0, irq}, 0);
        wr32('h018, 32'hFB);
        check("R10 unmasked", {63'b0, irq}, 1);
        wr32('h020, 32'h04);
        rd('h01C, 0, v); check("R9 cleared", v, 0);
        check("R10 quiet after clear", {63'b0, irq}, 0);

        // R9 wrap and clear in the same cycle: set wins
        wr64('h110, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        ev_pulse = 5'b10000;
        bus_wr = 1'b1; bus_wide = 1'b0; bus_addr = AW'('h020); bus_wdata = 64'h04;
        @(negedge clk);
        ev_pulse = '0; bus_wr = 1'b0;
        rd('h01C, 0, v); check("R9 set beats clear", v, 64'h04);

        // R11 write beats increment
        wr32('h00C, 32'h80);
        wr32('h014, 32'h09000000);
        settle();
        @(negedge clk);
        ev_pulse = 5'b10000;
        bus_wr = 1'b1; bus_wide = 1'b1; bus_addr = AW'('h138); bus_wdata = 64'd1000;
        @(negedge clk);
        bus_wr = 1'b0;
        rd('h138, 1, v); check("R11 written value", v, 1000);
        @(negedge clk);
        rd('h138, 1, v); check("R11 counts after", v, 1001);
        ev_pulse = '0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule